// File: doc/BRIEF.md
# Column-Bypassing Carry-Save Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. The operands pass through a grid of full-adder cells. Each column of the grid belongs to one bit of the multiplicand. When a multiplicand bit is zero, every cell in its column is bypassed. Its adder inputs are frozen, its sum output passes through the sum coming from the row above, and its carry output is forced to zero. A carry-propagate adder after the last row of the grid produces the upper half of the product. No correction logic follows the array.

Each row adds one multiplier-weighted row of partial products to the sums and carries of the row above. Carries move down one row and one weight position. A carry therefore never enters a column from a neighbouring column, so a bypassed column has no carry to pass on and the product stays exact.

Operands are captured on a clock edge where `in_valid` is high. A two-state pipeline controller has the states EMPTY and LOADED. The transition EMPTY→LOADED or LOADED→LOADED is taken when `in_valid` is high. The transition LOADED→EMPTY or EMPTY→EMPTY is taken when it is low. In state LOADED, the next edge registers the product and raises `out_valid` for one cycle.

Top module: `colbyp_mult`

## Requirements
- R1: After reset, `out_valid` is 0 and `product` is 0.
- R2: An operand pair captured on edge k appears on `product` after edge k+1 as the exact unsigned product `mcand*mplier`, with `out_valid` high.
- R3: Operand pairs accepted on consecutive edges give one `out_valid` cycle each, in order and with no gaps.
- R4: On an edge where `in_valid` is low, the operands are ignored. One edge later `out_valid` is 0 and `product` keeps its previous value.
- R5: A multiplicand of 0 bypasses every column and gives a product of 0.
- R6: A multiplicand with all bits set bypasses no column and gives the exact product.
- R7: A multiplier of 0 gives a product of 0 for any multiplicand.
- R8: In a bypassed column, the carry entering every cell below the first row is 0. Sparse multiplicands therefore give exact products.
- R9: While a column stays bypassed, the three adder inputs of each of its cells do not change.
- R10: With `WIDTH` = 4, the product is exact for all 256 operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present; capture on this edge |
| mcand | input | WIDTH | Multiplicand; bit j enables column j |
| mplier | input | WIDTH | Multiplier; bit i selects row i |
| out_valid | output | 1 | Product valid, one cycle per accepted pair |
| product | output | 2*WIDTH | Unsigned product |

## Verification
The assertions check four things on every cycle. The carry entering a bypassed column is zero. The adder inputs of a bypassed cell stay frozen. The controller follows `in_valid`. A valid product equals the product of the operands captured two edges earlier. Other properties show only through scenarios in the bench: the exhaustive 4-bit sweep, the all-zero and all-ones multiplicands, streaming without gaps, and the sparse random multiplicands that bypass many column patterns. These scenarios also show that ignored cycles leave the product untouched.

// File: rtl/colbyp_pkg.sv
package colbyp_pkg;

    // Two-state pipeline controller: operand stage empty or holding a pair
    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } colbyp_state_e;

endpackage

// File: rtl/colbyp_cell.sv
// One full-adder cell of the array with operand isolation and bypass path.
module colbyp_cell #(
    parameter bit FIRST_ROW = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_active,
    input  logic pp,
    input  logic s_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);

    logic [2:0] held_q;
    logic [2:0] live;
    logic [2:0] fa_in;
    logic       fa_sum;
    logic       fa_cry;

    assign live = {pp, s_in, c_in};

    // Frozen copy of the adder inputs; refreshed only while the column works
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (col_active) begin
            held_q <= live;
        end
    end

    // Operand isolation multiplexer
    always_comb begin
        fa_in = col_active ? live : held_q;
    end

    always_comb begin
        fa_sum = fa_in[2] ^ fa_in[1] ^ fa_in[0];
        fa_cry = (fa_in[2] & fa_in[1]) | (fa_in[2] & fa_in[0]) | (fa_in[1] & fa_in[0]);
    end

    // Bypass multiplexer: sum passes through, carry is zero
    always_comb begin
        s_out = col_active ? fa_sum : s_in;
        c_out = col_active ? fa_cry : 1'b0;
    end

    // R9: inputs of a cell in a column that stays bypassed never toggle
    assert_bypass_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_active && $past(!col_active)) |-> $stable(fa_in));

    generate
        if (!FIRST_ROW) begin : g_cin_chk
            // R8: a bypassed column never receives a carry from the row above
            assert_bypass_cin_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !col_active |-> (c_in == 1'b0));
        end
    endgenerate

endmodule

// File: rtl/colbyp_final_add.sv
// Carry-propagate stage resolving the last sum and carry vectors.
module colbyp_final_add #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] sum_vec,
    input  logic [WIDTH-1:0] cry_vec,
    output logic [WIDTH-1:0] result
);

    logic [WIDTH:0] rip;

    assign rip[0] = 1'b0;

    generate
        for (genvar k = 0; k < WIDTH; k++) begin : g_rca
            assign result[k]  = sum_vec[k] ^ cry_vec[k] ^ rip[k];
            assign rip[k + 1] = (sum_vec[k] & cry_vec[k]) | (rip[k] & (sum_vec[k] ^ cry_vec[k]));
        end
    endgenerate

endmodule

// File: rtl/colbyp_array.sv
// Carry-save grid: rows follow multiplier bits, columns follow multiplicand bits.
module colbyp_array #(
    parameter int WIDTH = 8,
    localparam int PW = 2 * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [PW-1:0]    prod
);

    logic [WIDTH-1:0] srow [WIDTH];
    logic [WIDTH-1:0] crow [WIDTH];
    logic [WIDTH-1:0] upper;

    // Row 0 holds the first partial-product row, with no carries
    assign srow[0] = op_a & {WIDTH{op_b[0]}};
    assign crow[0] = '0;

    generate
        for (genvar r = 1; r < WIDTH; r++) begin : g_row
            logic [WIDTH-1:0] s_shift;
            assign s_shift = {1'b0, srow[r-1][WIDTH-1:1]};
            for (genvar j = 0; j < WIDTH; j++) begin : g_col
                colbyp_cell #(
                    .FIRST_ROW(r == 1)
                ) u_cell (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .col_active(op_a[j]),
                    .pp        (op_a[j] & op_b[r]),
                    .s_in      (s_shift[j]),
                    .c_in      (crow[r-1][j]),
                    .s_out     (srow[r][j]),
                    .c_out     (crow[r][j])
                );
            end
        end
        for (genvar r = 0; r < WIDTH; r++) begin : g_low
            assign prod[r] = srow[r][0];
        end
    endgenerate

    colbyp_final_add #(
        .WIDTH(WIDTH)
    ) u_final (
        .sum_vec({1'b0, srow[WIDTH-1][WIDTH-1:1]}),
        .cry_vec(crow[WIDTH-1]),
        .result (upper)
    );

    assign prod[PW-1:WIDTH] = upper;

endmodule

// File: rtl/colbyp_mult.sv
// Registered column-bypassing multiplier with a two-state pipeline controller.
module colbyp_mult
    import colbyp_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int PW = 2 * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    output logic             out_valid,
    output logic [PW-1:0]    product
);

    colbyp_state_e    state_q;
    colbyp_state_e    state_d;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic [PW-1:0]    arr_prod;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // State register and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            a_q     <= '0;
            b_q     <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                a_q <= mcand;
                b_q <= mplier;
            end
        end
    end

    colbyp_array #(
        .WIDTH(WIDTH)
    ) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .op_a (a_q),
        .op_b (b_q),
        .prod (arr_prod)
    );

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            unique case (state_q)
                ST_LOADED: begin
                    out_valid <= 1'b1;
                    product   <= arr_prod;
                end
                ST_EMPTY: begin
                    out_valid <= 1'b0;
                end
                default: out_valid <= 1'b0;
            endcase
        end
    end

    // R3: an accepted pair moves the controller to LOADED
    assert_accept_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (state_q == ST_LOADED));

    // R4: an idle input cycle empties the operand stage
    assert_idle_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (state_q == ST_EMPTY));

    // R4: an empty stage yields no valid and leaves the product untouched
    assert_empty_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) |=> (!out_valid && $stable(product)));

    // R2: a valid product equals the operands captured two edges earlier
    assert_prod_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (product == (PW'($past(mcand, 2)) * PW'($past(mplier, 2)))));

endmodule

// File: tb/test_colbyp_mult.sv
module test_colbyp_mult;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic        iv8 = 1'b0;
    logic [7:0]  a8 = '0;
    logic [7:0]  b8 = '0;
    logic        ov8;
    logic [15:0] p8;

    logic        iv4 = 1'b0;
    logic [3:0]  a4 = '0;
    logic [3:0]  b4 = '0;
    logic        ov4;
    logic [7:0]  p4;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    colbyp_mult #(.WIDTH(8)) i_colbyp_mult (
        .clk(clk), .rst_n(rst_n), .in_valid(iv8), .mcand(a8), .mplier(b8),
        .out_valid(ov8), .product(p8)
    );

    colbyp_mult #(.WIDTH(4)) i_colbyp_mult_n4 (
        .clk(clk), .rst_n(rst_n), .in_valid(iv4), .mcand(a4), .mplier(b4),
        .out_valid(ov4), .product(p4)
    );

    function automatic logic [16:0] ref8(input logic [7:0] a, input logic [7:0] b);
        return {1'b1, 16'(16'(a) * 16'(b))};
    endfunction

    function automatic logic [8:0] ref4(input logic [3:0] a, input logic [3:0] b);
        return {1'b1, 8'(8'(a) * 8'(b))};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [16:0] act, input logic [16:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one pair, release, sample two edges after capture
    task automatic one8(input logic [7:0] a, input logic [7:0] b, input string req);
        @(negedge clk);
        iv8 = 1'b1; a8 = a; b8 = b;
        @(negedge clk);
        iv8 = 1'b0; a8 = 8'($urandom); b8 = 8'($urandom);
        @(negedge clk);
        chk({ov8, p8} === ref8(a, b), req, {ov8, p8}, ref8(a, b));
    endtask

    task automatic one4(input logic [3:0] a, input logic [3:0] b, input string req);
        @(negedge clk);
        iv4 = 1'b1; a4 = a; b4 = b;
        @(negedge clk);
        iv4 = 1'b0; a4 = 4'($urandom); b4 = 4'($urandom);
        @(negedge clk);
        chk({ov4, p4} === ref4(a, b), req, {8'h0, ov4, p4}, {8'h0, ref4(a, b)});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  sa [6];
        logic [7:0]  sb [6];
        logic [15:0] keep;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        // R1: reset state of both instances
        chk({ov8, p8} === 17'h0, "R1", {ov8, p8}, 17'h0);
        chk({ov4, p4} === 9'h0, "R1", {8'h0, ov4, p4}, 17'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ov8, p8} === 17'h0, "R1", {ov8, p8}, 17'h0);

        // R5: all columns bypassed
        one8(8'h00, 8'hFF, "R5");
        one8(8'h00, 8'h5A, "R5");
        // R6: no column bypassed
        one8(8'hFF, 8'hFF, "R6");
        one8(8'hFF, 8'h01, "R6");
        one8(8'hFF, 8'hA7, "R6");
        // R7: zero multiplier
        one8(8'hFF, 8'h00, "R7");
        one8(8'h93, 8'h00, "R7");

        // R4: idle cycles with changing operands leave outputs alone
        one8(8'hC3, 8'h7E, "R2");
        keep = p8;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a8 = 8'($urandom); b8 = 8'($urandom);
            chk({ov8, p8} === {1'b0, keep}, "R4", {ov8, p8}, {1'b0, keep});
        end

        // R3: back-to-back stream, vector t-2 seen at negedge t
        for (int k = 0; k < 6; k++) begin
            sa[k] = 8'($urandom);
            sb[k] = 8'($urandom);
        end
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            if (t >= 2)
                chk({ov8, p8} === ref8(sa[t-2], sb[t-2]), "R3", {ov8, p8}, ref8(sa[t-2], sb[t-2]));
            if (t < 6) begin
                iv8 = 1'b1; a8 = sa[t]; b8 = sb[t];
            end else begin
                iv8 = 1'b0;
            end
        end
        @(negedge clk);
        chk(ov8 === 1'b0, "R3", {16'h0, ov8}, 17'h0);

        // R8: single-bit and sparse multiplicands, many bypass patterns
        for (int j = 0; j < 8; j++)
            one8(8'(1 << j), 8'($urandom), "R8");
        for (int k = 0; k < 600; k++)
            one8(8'($urandom & $urandom & $urandom), 8'($urandom), "R8");
        // R9: alternate bypass patterns on a dense multiplier
        for (int k = 0; k < 100; k++)
            one8(8'($urandom & $urandom), 8'hFF, "R9");
        // R2: dense random
        for (int k = 0; k < 800; k++)
            one8(8'($urandom), 8'($urandom), "R2");

        // R10: exhaustive 4-bit sweep
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                one4(4'(x), 4'(y), "R10");

        finish_run();
    end

endmodule